// File: doc/BRIEF.md
# Vector Lane to Scalar Move Unit

This unit decodes a single instruction word that moves one lane of a 128-bit vector register into a general-purpose register. The lane is either sign-extended or zero-extended. The vector operand has already been read from the register file by the caller and arrives alongside the instruction.

A 5-bit packed field selects both the lane width and the lane number. Its lowest set bit gives the width, and the bits above that bit give the lane. Each move form accepts only certain widths for each destination size. A decoded move with an illegal width or destination raises an unallocated-encoding flag and does not write.

Results pass through one register stage. The stage returns the destination register number, a 64-bit value, a write-enable and the flag, together with a valid bit one cycle after the valid input.

Top module: `vmov_unit`

## Requirements
- R1: An instruction matches only when bit 31 is 0, bits 29:21 equal 0x070 and bits 15:10 equal 0x0B (sign-extending form) or 0x0F (zero-extending form). A word that does not match produces neither a write nor the unallocated flag.
- R2: In the field at bits 20:16, the lowest set bit selects the lane width and the bits above it select the lane:
  - bit 0 selects byte, with lane = bits 4:1.
  - bit 1 selects halfword, with lane = bits 4:2.
  - bit 2 selects word, with lane = bits 4:3.
  - bit 3 selects doubleword, with lane = bit 4.
  Lanes are little-endian: lane 0 starts at vector bit 0.
- R3: Bit 30 selects the destination size: 0 is 32-bit and 1 is 64-bit. The sign-extending form is legal for byte and halfword with a 32-bit destination, and for byte, halfword and word with a 64-bit destination. Every other case raises the flag.
- R4: The zero-extending form is legal for byte, halfword and word with a 32-bit destination, and only for doubleword with a 64-bit destination. Every other case raises the flag.
- R5: For a 32-bit destination, result bits 63:32 are zero. For a legal sign-extending move, the element is sign-extended to the destination width.
- R6: A legal zero-extending move returns the element with all upper bits zero.
- R7: The output valid rises exactly one cycle after an input valid and is low otherwise. Reset clears it.
- R8: The write-enable and the flag are never high together, and both are low when the output valid is low. The result is zero when no write occurs.
- R9: The returned destination number equals bits 4:0 of the instruction from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and vector are valid |
| instr | input | 32 | Instruction word |
| vec | input | 128 | Source vector value |
| out_valid | output | 1 | Registered result valid |
| out_rd | output | 5 | Destination register number |
| out_data | output | 64 | Extended result |
| out_we | output | 1 | Write the destination register |
| out_unalloc | output | 1 | Matching move with illegal width/destination |

## Verification
The hardest cases to reach are the boundaries of the legality rules. Examples are a sign-extending word move into a 32-bit destination, a zero-extending doubleword into a 32-bit destination, a field with no low bit set, and a top-lane element with its sign bit set.

Uniform random instruction words almost never match the fixed fields. The stimulus therefore builds words with the fixed fields already correct and draws the form, destination size and packed field at random. It also sends a small share of fully random words. Directed cases add the worked lane values from a known vector and each illegal width and destination pairing.

// File: rtl/vmov_pkg.sv
package vmov_pkg;
  typedef enum logic [2:0] {
    SZ_B    = 3'd0,
    SZ_H    = 3'd1,
    SZ_W    = 3'd2,
    SZ_D    = 3'd3,
    SZ_NONE = 3'd4
  } esize_e;

  typedef struct packed {
    logic       hit;
    logic       sext;
    logic       wide;
    esize_e     sz;
    logic [3:0] lane;
    logic [4:0] rd;
  } dec_t;

  localparam logic [8:0] FIXED_MID = 9'h070;
  localparam logic [5:0] OP_SEXT   = 6'h0B;
  localparam logic [5:0] OP_ZEXT   = 6'h0F;
endpackage

// File: rtl/vmov_decode.sv
module vmov_decode
  import vmov_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec,
  output logic               legal
);
  logic [4:0] fld;
  logic [5:0] opc;

  always_comb begin
    fld      = instr[20:16];
    opc      = instr[15:10];
    dec.rd   = instr[4:0];
    dec.wide = instr[30];
    dec.sext = (opc == OP_SEXT);
    dec.hit  = !instr[31] && (instr[29:21] == FIXED_MID) &&
               ((opc == OP_SEXT) || (opc == OP_ZEXT));
    dec.lane = '0;
    dec.sz   = SZ_NONE;
    if (fld[0]) begin
      dec.sz   = SZ_B;
      dec.lane = fld[4:1];
    end else if (fld[1]) begin
      dec.sz   = SZ_H;
      dec.lane = {1'b0, fld[4:2]};
    end else if (fld[2]) begin
      dec.sz   = SZ_W;
      dec.lane = {2'b00, fld[4:3]};
    end else if (fld[3]) begin
      dec.sz   = SZ_D;
      dec.lane = {3'b000, fld[4]};
    end
  end

  always_comb begin
    legal = 1'b0;
    unique case ({dec.sext, dec.wide})
      2'b10: legal = (dec.sz == SZ_B) || (dec.sz == SZ_H);
      2'b11: legal = (dec.sz == SZ_B) || (dec.sz == SZ_H) || (dec.sz == SZ_W);
      2'b00: legal = (dec.sz == SZ_B) || (dec.sz == SZ_H) || (dec.sz == SZ_W);
      2'b01: legal = (dec.sz == SZ_D);
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/vmov_lane_sel.sv
module vmov_lane_sel
  import vmov_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int XLEN  = 64,
  parameter int NSIZE = 4
) (
  input  logic [VEC_W-1:0] vec,
  input  esize_e           sz,
  input  logic [3:0]       lane,
  input  logic             sext,
  input  logic             wide,
  output logic [XLEN-1:0]  res
);
  localparam int OFF_W = $clog2(VEC_W);
  localparam int HALF  = XLEN / 2;

  logic [OFF_W-1:0] off;
  logic [VEC_W-1:0] shifted;
  logic [XLEN-1:0]  cand [NSIZE];

  always_comb begin
    unique case (sz)
      SZ_B:    off = OFF_W'({lane, 3'b000});
      SZ_H:    off = OFF_W'({lane[2:0], 4'b0000});
      SZ_W:    off = OFF_W'({lane[1:0], 5'b00000});
      SZ_D:    off = OFF_W'({lane[0], 6'b000000});
      default: off = '0;
    endcase
    shifted = vec >> off;
  end

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int EW = 8 << g;
    logic [EW-1:0] el;
    assign el = shifted[EW-1:0];
    if (EW < XLEN) begin : g_ext
      assign cand[g] = sext ? {{(XLEN-EW){el[EW-1]}}, el}
                            : {{(XLEN-EW){1'b0}}, el};
    end else begin : g_full
      assign cand[g] = el;
    end
  end

  always_comb begin
    logic [XLEN-1:0] pick;
    unique case (sz)
      SZ_B:    pick = cand[0];
      SZ_H:    pick = cand[1];
      SZ_W:    pick = cand[2];
      SZ_D:    pick = cand[3];
      default: pick = '0;
    endcase
    res = wide ? pick : {{(XLEN-HALF){1'b0}}, pick[HALF-1:0]};
  end
endmodule

// File: rtl/vmov_out_stage.sv
module vmov_out_stage #(
  parameter int XLEN = 64,
  parameter int RN_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            we_d,
  input  logic            un_d,
  input  logic [RN_W-1:0] rd_d,
  input  logic [XLEN-1:0] data_d,
  output logic            out_valid,
  output logic            out_we,
  output logic            out_unalloc,
  output logic [RN_W-1:0] out_rd,
  output logic [XLEN-1:0] out_data
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       v_n, we_n, un_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    v_n  = in_valid;
    we_n = in_valid & we_d;
    un_n = in_valid & un_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid   <= 1'b0;
      out_we      <= 1'b0;
      out_unalloc <= 1'b0;
    end else begin
      out_valid   <= v_n;
      out_we      <= we_n;
      out_unalloc <= un_n;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_rd   <= rd_d;
      out_data <= data_d;
    end
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(out_we && out_unalloc));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !out_valid |-> (!out_we && !out_unalloc));
  p_valid_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);
  p_novalid_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);
  p_zero_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && !out_we) |-> (out_data == '0));
endmodule

// File: rtl/vmov_unit.sv
module vmov_unit
  import vmov_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int VEC_W   = 128,
  parameter int XLEN    = 64,
  parameter int RN_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [VEC_W-1:0]   vec,
  output logic               out_valid,
  output logic [RN_W-1:0]    out_rd,
  output logic [XLEN-1:0]    out_data,
  output logic               out_we,
  output logic               out_unalloc
);
  localparam int HALF = XLEN / 2;

  dec_t            dec;
  logic            legal;
  logic [XLEN-1:0] lane_val;
  logic            we_d, un_d;
  logic [XLEN-1:0] data_d;

  vmov_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr (instr),
    .dec   (dec),
    .legal (legal)
  );

  vmov_lane_sel #(.VEC_W(VEC_W), .XLEN(XLEN)) u_sel (
    .vec  (vec),
    .sz   (dec.sz),
    .lane (dec.lane),
    .sext (dec.sext),
    .wide (dec.wide),
    .res  (lane_val)
  );

  always_comb begin
    we_d   = dec.hit && legal;
    un_d   = dec.hit && !legal;
    data_d = we_d ? lane_val : '0;
  end

  vmov_out_stage #(.XLEN(XLEN), .RN_W(RN_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .we_d        (we_d),
    .un_d        (un_d),
    .rd_d        (dec.rd),
    .data_d      (data_d),
    .out_valid   (out_valid),
    .out_we      (out_we),
    .out_unalloc (out_unalloc),
    .out_rd      (out_rd),
    .out_data    (out_data)
  );

  p_nohit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31]) |=> (!out_we && !out_unalloc));
  p_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !instr[30]) |=> (out_data[XLEN-1:HALF] == '0));
  p_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_rd == $past(instr[4:0])));
  p_dword32_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !instr[31] && instr[29:21] == FIXED_MID &&
     instr[15:10] == OP_ZEXT && !instr[30] && instr[19:16] == 4'b1000)
    |=> out_unalloc);
endmodule

// File: tb/vmov_unit_test.sv
`timescale 1ns/1ps
module vmov_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  instr;
  logic [127:0] vec;
  logic         out_valid, out_we, out_unalloc;
  logic [4:0]   out_rd;
  logic [63:0]  out_data;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  vmov_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .vec(vec),
    .out_valid(out_valid), .out_rd(out_rd), .out_data(out_data),
    .out_we(out_we), .out_unalloc(out_unalloc)
  );

  localparam logic [127:0] KVEC =
    {32'hF8F7F6F5, 32'hF4F3F2F1, 32'h08070605, 32'h04030201};

  function automatic logic [65:0] model(logic [31:0] i, logic [127:0] v);
    logic hit, sg, w, ok;
    logic [4:0] f;
    int k, lane, eb;
    logic [127:0] sh;
    logic [63:0] x;
    hit = !i[31] && i[29:21] == 9'h070 && (i[15:10] == 6'h0B || i[15:10] == 6'h0F);
    if (!hit) return '0;
    sg = (i[15:10] == 6'h0B);
    w  = i[30];
    f  = i[20:16];
    k  = -1;
    for (int j = 0; j < 4; j++) if (f[j] && k < 0) k = j;
    if (sg) ok = (k == 0 || k == 1 || (k == 2 && w));
    else    ok = w ? (k == 3) : (k >= 0 && k <= 2);
    if (!ok) return {1'b0, 1'b1, 64'h0};
    lane = int'(f) >> (k + 1);
    eb   = 8 << k;
    sh   = v >> (lane * eb);
    x    = '0;
    for (int b = 0; b < 64; b++)
      x[b] = (b < eb) ? sh[b] : (sg ? sh[eb-1] : 1'b0);
    if (!w) x[63:32] = '0;
    return {1'b1, 1'b0, x};
  endfunction

  function automatic logic [31:0] mk(bit sg, bit w, logic [4:0] f, logic [4:0] rd);
    return {1'b0, w, 9'h070, f, (sg ? 6'h0B : 6'h0F), 5'd3, rd};
  endfunction

  task automatic apply(logic [31:0] i, logic [127:0] v, string tag);
    logic [65:0] e;
    instr = i; vec = v; in_valid = 1'b1;
    e = model(i, v);
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b1 || out_rd !== i[4:0] || out_we !== e[65] ||
        out_unalloc !== e[64] || out_data !== e[63:0]) begin
      n_bad++;
      $display("FAIL %s instr=%h: got v=%b rd=%0d we=%b un=%b data=%h, exp v=1 rd=%0d we=%b un=%b data=%h",
               tag, i, out_valid, out_rd, out_we, out_unalloc, out_data,
               i[4:0], e[65], e[64], e[63:0]);
    end
  endtask

  task automatic idle_check();
    in_valid = 1'b0;
    instr = 32'hFFFF_FFFF;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || out_we !== 1'b0 || out_unalloc !== 1'b0) begin
      n_bad++;
      $display("FAIL R7 idle: got v=%b we=%b un=%b, exp 0 0 0",
               out_valid, out_we, out_unalloc);
    end
  endtask

  initial begin
    int unused;
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; vec = '0;
    unused = $urandom(32'h5EED_0C7A);
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || out_we !== 1'b0 || out_unalloc !== 1'b0) begin
      n_bad++;
      $display("FAIL R7 reset: got v=%b we=%b un=%b, exp 0 0 0",
               out_valid, out_we, out_unalloc);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Worked lane values (R5, R6, R2)
    apply(mk(1, 0, 5'b11001, 5'd1), KVEC, "R5 sbyte lane12 w32");
    apply(mk(1, 1, 5'b11001, 5'd2), KVEC, "R5 sbyte lane12 w64");
    apply(mk(1, 0, 5'b10010, 5'd3), KVEC, "R5 shalf lane4");
    apply(mk(0, 0, 5'b11001, 5'd4), KVEC, "R6 ubyte lane12");
    apply(mk(0, 0, 5'b10010, 5'd5), KVEC, "R6 uhalf lane4");
    apply(mk(1, 1, 5'b11100, 5'd6), KVEC, "R2 sword lane3");
    apply(mk(0, 1, 5'b11000, 5'd7), KVEC, "R2 udword lane1");
    apply(mk(0, 0, 5'b11111, 5'd8), KVEC, "R2 ubyte lane15");
    // Legality boundaries (R3, R4)
    apply(mk(1, 0, 5'b00100, 5'd9),  KVEC, "R3 sword w32 illegal");
    apply(mk(1, 1, 5'b01000, 5'd10), KVEC, "R3 sdword illegal");
    apply(mk(1, 1, 5'b00000, 5'd11), KVEC, "R3 empty field");
    apply(mk(0, 0, 5'b01000, 5'd12), KVEC, "R4 udword w32 illegal");
    apply(mk(0, 1, 5'b00001, 5'd13), KVEC, "R4 ubyte w64 illegal");
    apply(mk(0, 0, 5'b00000, 5'd14), KVEC, "R4 empty field");
    // Non-matching words (R1)
    apply(mk(1, 1, 5'b00001, 5'd15) | 32'h8000_0000, KVEC, "R1 bit31 set");
    apply(mk(0, 0, 5'b00001, 5'd16) ^ 32'h0020_0000, KVEC, "R1 mid field");
    apply({mk(0, 0, 5'b00001, 5'd17)} & ~32'h0000_0400, KVEC, "R1 opcode 0x0E");
    idle_check();
    apply(mk(1, 1, 5'b00011, 5'd31), KVEC, "R9 rd 31");
    idle_check();

    for (int n = 0; n < 600; n++) begin
      logic [31:0]  iw;
      logic [127:0] vv;
      vv = {$urandom, $urandom, $urandom, $urandom};
      if (n % 10 == 9) iw = $urandom;
      else iw = mk(1'($urandom), 1'($urandom), 5'($urandom), 5'($urandom));
      apply(iw, vv, "R8 random");
      if (n % 37 == 0) idle_check();
    end
    idle_check();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: got running, exp done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule